// File: doc/BRIEF.md
# Inclusive Last-Level Cache Coherence Directory

This block is the tag and directory controller of a shared last-level cache that contains every line held in the private caches of several cores. Each way of a set keeps a tag, a per-core presence vector, a five-state coherence state (I, S, E, F, M), the identity of the core holding the forwarding role, and a dirty bit that records whether the shared copy differs from memory. Cores send read, read-for-ownership and writeback requests with their core number over a valid/ready channel. For each request the controller decides, from the stored presence and state, which cores (if any) receive an invalidate or forward snoop, whether a victim must be written to memory, and whether the line must be fetched. It then returns the state granted to the requester.

Because the cache is inclusive, a tag miss proves that no core holds the line, so a miss never snoops the requester's peers. Only the cores flagged in the presence vector of the hit line, or of an evicted victim, are contacted. One request is handled at a time. The request channel stays closed until the snoop acknowledgement, the memory completions and the response have all occurred. Data arrays, memory timing and the interconnect are outside the block and appear only as handshake ports.

Top module: `llc_dir_ctrl`

## Requirements
- R1: After synchronous reset, req_ready is 1, rsp_valid, snp_valid and mem_valid are 0, and every line is absent, so the first read of any address is a miss.
- R2: A request that misses (req_op 0 = read, 1 = read-for-ownership) into an empty way issues no snoop, one memory read (mem_write = 0) of the request address, and grants rsp_state E (code 2) for a read or M (code 4) for a read-for-ownership, with the new line flagged only for the requester.
- R3: A read that hits a line held in E or M by one other core sends a forward snoop (snp_kind 1) to that core only. For M the line is then written to memory (mem_write = 1) before the response. The requester is granted F (code 3).
- R4: A read that hits a line in F from a core not yet present sends a forward snoop to the current forwarder only. The requester receives F, and the forwarding role moves to it, so the next such read snoops the newest reader.
- R5: A read whose requester is the only flagged core, or that hits a line no core holds, is answered without snoop or memory access. It grants E when no core held the line, the stored state when the requester is the sole holder, and S (code 1) when the requester is one of several holders but not the forwarder.
- R6: A read-for-ownership that hits sends an invalidate snoop (snp_kind 0) whose mask is exactly the other flagged cores, or no snoop when there are none. It makes no memory access, grants M, and leaves only the requester flagged.
- R7: A writeback (req_op 2) answers with state I (code 0) and no memory access. It clears the requester's presence flag, and marks the shared copy dirty when the line was M. A departing forwarder leaves the line in S, so the next new reader is served locally and granted F. A line with no holders left is granted E to the next reader without snoop. A writeback that misses changes nothing.
- R8: On a miss, an empty way of the set is chosen first, and otherwise the tree pseudo-LRU victim (the way not most recently filled or hit by a read or read-for-ownership). Every core flagged on the victim receives an invalidate snoop of the victim address. A victim that is dirty or in M is written to memory before the fill.
- R9: While a snoop or memory access is outstanding, req_ready is 0, and snp_valid or mem_valid stays high with stable mask, kind, address and direction until snp_ack or mem_done.
- R10: Every accepted request yields exactly one rsp_valid pulse, one cycle long, carrying the requester's core number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_op | input | 2 | 0 read, 1 read-for-ownership, 2 writeback |
| req_core | input | CID_W | Requesting core number |
| req_addr | input | ADDR_W | Line address (low bits select the set) |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_core | output | CID_W | Core the response is for |
| rsp_state | output | 3 | Granted state: I0 S1 E2 F3 M4 |
| snp_valid | output | 1 | Snoop message pending |
| snp_kind | output | 1 | 0 invalidate, 1 forward |
| snp_mask | output | NCORES | Cores that receive the snoop |
| snp_addr | output | ADDR_W | Line the snoop refers to |
| snp_ack | input | 1 | All targeted cores have answered |
| mem_valid | output | 1 | Memory access pending |
| mem_write | output | 1 | 1 writeback to memory, 0 fetch |
| mem_addr | output | ADDR_W | Line address of the access |
| mem_done | input | 1 | Memory access completed |

## Verification
The embedded assertions watch, on every cycle, the handshake discipline: the request channel stays closed while a snoop or memory access is pending, snoop and memory requests hold steady until acknowledged, and responses are single pulses. They also check that a forward snoop always names exactly one core, and that a line being granted E or M or given a forwarder is consistent with its presence vector. Only the bench's request sequences show the coherence decisions themselves. These are which cores a snoop reaches, the forwarding role moving to the newest reader, dirty victims written before a refill, the invalid-first and pseudo-LRU victim order, and a reset that empties the directory. The bench compares every snoop, memory access and grant against values worked out from the requirements for a scripted history of each line.

// File: rtl/llc_dir_pkg.sv
package llc_dir_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_F = 3'd3,
    ST_M = 3'd4
  } mesif_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_RFO = 2'd1,
    OP_WB  = 2'd2
  } req_op_e;

  typedef enum logic {
    SK_INV = 1'b0,
    SK_FWD = 1'b1
  } snp_kind_e;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_LOOK,
    FS_SNP,
    FS_WB,
    FS_FILL,
    FS_DONE
  } fsm_e;
endpackage

// File: rtl/llc_dir_store.sv
// One wide record per set, written whole, read synchronously.
module llc_dir_store #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/llc_dir_plru.sv
// Tree pseudo-LRU: each node bit points toward the next victim half.
module llc_dir_plru #(
  parameter int WAYS = 2,
  localparam int LW  = $clog2(WAYS),
  localparam int PW  = WAYS - 1
) (
  input  logic [PW-1:0]   bits,
  input  logic [WAYS-1:0] valid,
  input  logic [LW-1:0]   touch,
  output logic [LW-1:0]   victim,
  output logic [PW-1:0]   bits_next
);
  always_comb begin
    int   node;
    logic found;
    node = 1;
    for (int l = 0; l < LW; l++) node = 2 * node + int'(bits[node-1]);
    victim = LW'(node - WAYS);
    found  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid[w]) begin
        victim = LW'(w);
        found  = 1'b1;
      end
    end
    bits_next = bits;
    node      = 1;
    for (int l = 0; l < LW; l++) begin
      bits_next[node-1] = ~touch[LW-1-l];
      node = 2 * node + int'(touch[LW-1-l]);
    end
  end
endmodule

// File: rtl/llc_dir_ctrl.sv
module llc_dir_ctrl
  import llc_dir_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int ADDR_W = 8,
  localparam int CID_W = $clog2(NCORES),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int LW    = $clog2(WAYS),
  localparam int PW    = WAYS - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [CID_W-1:0]  req_core,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [CID_W-1:0]  rsp_core,
  output logic [2:0]        rsp_state,
  output logic              snp_valid,
  output logic              snp_kind,
  output logic [NCORES-1:0] snp_mask,
  output logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_ack,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_done
);
  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    mesif_e            st;
    logic [NCORES-1:0] pres;
    logic [CID_W-1:0]  fwd;
    logic              dirty;
  } line_t;

  typedef struct packed {
    line_t [WAYS-1:0] way;
    logic  [PW-1:0]   plru;
  } set_t;

  localparam int SET_W = $bits(set_t);

  fsm_e                   st;
  req_op_e                q_op;
  logic [CID_W-1:0]       q_core;
  logic [ADDR_W-1:0]      q_addr;
  logic [SETS-1:0][WAYS-1:0] vld;
  set_t                   rd_set, wr_set;
  logic                   st_we;

  // plan registers captured in the lookup cycle
  logic [NCORES-1:0] p_mask;
  snp_kind_e         p_kind;
  logic [ADDR_W-1:0] p_snaddr, p_wbaddr;
  logic              p_wb, p_fill, p_upd;
  logic [LW-1:0]     p_way;
  line_t             p_line;
  mesif_e            p_rsp;
  logic [PW-1:0]     p_plru;

  logic [IDX_W-1:0]  idx, rd_idx;
  logic [TAG_W-1:0]  tag;
  logic              hit;
  logic [LW-1:0]     hw, victim, way;
  logic [PW-1:0]     plru_nx;
  line_t             cur, n_line;
  logic [NCORES-1:0] cbit, others, n_mask;
  snp_kind_e         n_kind;
  logic [ADDR_W-1:0] n_snaddr, n_wbaddr;
  logic              n_wb, n_fill, n_upd;
  mesif_e            n_rsp;

  assign idx    = q_addr[IDX_W-1:0];
  assign tag    = q_addr[ADDR_W-1:IDX_W];
  assign rd_idx = (st == FS_IDLE) ? req_addr[IDX_W-1:0] : idx;

  llc_dir_store #(.W(SET_W), .DEPTH(SETS)) u_store (
    .clk(clk), .we(st_we), .waddr(idx), .wdata(wr_set),
    .raddr(rd_idx), .rdata(rd_set)
  );

  always_comb begin
    hit = 1'b0;
    hw  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit && vld[idx][w] && rd_set.way[w].tag == tag) begin
        hit = 1'b1;
        hw  = LW'(w);
      end
    end
  end

  assign way = hit ? hw : victim;

  llc_dir_plru #(.WAYS(WAYS)) u_plru (
    .bits(rd_set.plru), .valid(vld[idx]), .touch(way),
    .victim(victim), .bits_next(plru_nx)
  );

  assign cur    = rd_set.way[way];
  assign cbit   = NCORES'(1) << q_core;
  assign others = cur.pres & ~cbit;

  // coherence decision for the looked-up line
  always_comb begin
    n_mask = '0; n_kind = SK_INV; n_snaddr = q_addr;
    n_wb = 1'b0; n_wbaddr = q_addr; n_fill = 1'b0;
    n_line = cur; n_rsp = ST_I; n_upd = 1'b1;
    if (!hit) begin
      if (q_op == OP_WB) n_upd = 1'b0;
      else begin
        if (vld[idx][way]) begin
          n_mask   = cur.pres;
          n_snaddr = {cur.tag, idx};
          n_wb     = cur.dirty || cur.st == ST_M;
          n_wbaddr = {cur.tag, idx};
        end
        n_fill       = 1'b1;
        n_line.tag   = tag;
        n_line.st    = (q_op == OP_RFO) ? ST_M : ST_E;
        n_line.pres  = cbit;
        n_line.fwd   = q_core;
        n_line.dirty = 1'b0;
        n_rsp        = n_line.st;
      end
    end else begin
      case (q_op)
        OP_RD: begin
          if (others == '0) begin
            if (!cur.pres[q_core]) begin
              n_line.st = ST_E; n_line.pres = cbit; n_line.fwd = q_core;
            end
            n_rsp = n_line.st;
          end else if (cur.pres[q_core]) begin
            n_rsp = (cur.st == ST_F && cur.fwd == q_core) ? ST_F : ST_S;
          end else begin
            if (cur.st == ST_M || cur.st == ST_E) begin
              n_mask = others; n_kind = SK_FWD;
              if (cur.st == ST_M) begin
                n_wb = 1'b1; n_line.dirty = 1'b0;
              end
            end else if (cur.st == ST_F) begin
              n_mask = NCORES'(1) << cur.fwd; n_kind = SK_FWD;
            end
            n_line.st = ST_F; n_line.fwd = q_core;
            n_line.pres = cur.pres | cbit; n_rsp = ST_F;
          end
        end
        OP_RFO: begin
          n_mask = others;
          if (cur.st == ST_M && others != '0) n_line.dirty = 1'b1;
          n_line.st = ST_M; n_line.pres = cbit; n_line.fwd = q_core;
          n_rsp = ST_M;
        end
        default: begin
          if (cur.pres[q_core]) begin
            n_line.pres = cur.pres & ~cbit;
            if (cur.st == ST_M) n_line.dirty = 1'b1;
            if (n_line.pres == '0) n_line.st = ST_I;
            else if (cur.st == ST_F && cur.fwd == q_core) n_line.st = ST_S;
          end
          n_rsp = ST_I;
        end
      endcase
    end
  end

  always_comb begin
    wr_set = rd_set;
    wr_set.way[p_way] = p_line;
    wr_set.plru = p_plru;
  end
  assign st_we = (st == FS_DONE) && p_upd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= FS_IDLE; vld <= '0;
      q_op <= OP_RD; q_core <= '0; q_addr <= '0;
      p_mask <= '0; p_kind <= SK_INV; p_snaddr <= '0; p_wbaddr <= '0;
      p_wb <= 1'b0; p_fill <= 1'b0; p_upd <= 1'b0; p_way <= '0;
      p_line <= '0; p_rsp <= ST_I; p_plru <= '0;
    end else begin
      case (st)
        FS_IDLE: if (req_valid) begin
          q_op <= req_op_e'(req_op); q_core <= req_core; q_addr <= req_addr;
          st <= FS_LOOK;
        end
        FS_LOOK: begin
          p_mask <= n_mask; p_kind <= n_kind; p_snaddr <= n_snaddr;
          p_wb <= n_wb; p_wbaddr <= n_wbaddr; p_fill <= n_fill;
          p_upd <= n_upd; p_way <= way; p_line <= n_line; p_rsp <= n_rsp;
          p_plru <= (q_op == OP_WB) ? rd_set.plru : plru_nx;
          if (n_mask != '0) st <= FS_SNP;
          else if (n_wb)    st <= FS_WB;
          else if (n_fill)  st <= FS_FILL;
          else              st <= FS_DONE;
        end
        FS_SNP: if (snp_ack)
          st <= p_wb ? FS_WB : (p_fill ? FS_FILL : FS_DONE);
        FS_WB: if (mem_done) st <= p_fill ? FS_FILL : FS_DONE;
        FS_FILL: if (mem_done) st <= FS_DONE;
        default: begin
          if (p_upd) vld[idx][p_way] <= 1'b1;
          st <= FS_IDLE;
        end
      endcase
    end
  end

  assign req_ready = (st == FS_IDLE);
  assign rsp_valid = (st == FS_DONE);
  assign rsp_core  = q_core;
  assign rsp_state = p_rsp;
  assign snp_valid = (st == FS_SNP);
  assign snp_kind  = p_kind;
  assign snp_mask  = p_mask;
  assign snp_addr  = p_snaddr;
  assign mem_valid = (st == FS_WB) || (st == FS_FILL);
  assign mem_write = (st == FS_WB);
  assign mem_addr  = (st == FS_WB) ? p_wbaddr : q_addr;

  // R9: request channel closed while anything is outstanding
  p_closed_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (snp_valid || mem_valid) |-> !req_ready);
  // R9: snoop message held until acknowledged
  p_snp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && !snp_ack) |=> (snp_valid && $stable(snp_mask) &&
                                 $stable(snp_kind) && $stable(snp_addr)));
  // R9: memory access held until completion
  p_mem_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_done) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));
  // R4: a forward snoop names exactly one core
  p_fwd_single_r4: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_kind == SK_FWD) |-> $countones(snp_mask) == 1);
  // R10: responses are single-cycle pulses
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R6: an owning state is recorded with a single presence flag
  p_owner_alone_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && p_upd && (p_line.st == ST_M || p_line.st == ST_E))
      |-> $countones(p_line.pres) == 1);
  // R4: the forwarder is one of the flagged cores
  p_fwd_present_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && p_upd && p_line.st == ST_F) |-> p_line.pres[p_line.fwd]);
endmodule

// File: tb/llc_dir_ctrl_test.sv
module llc_dir_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = '0;
  logic [1:0] req_core = '0;
  logic [7:0] req_addr = '0;
  logic       rsp_valid;
  logic [1:0] rsp_core;
  logic [2:0] rsp_state;
  logic       snp_valid, snp_kind;
  logic [3:0] snp_mask;
  logic [7:0] snp_addr;
  logic       snp_ack = 1'b0;
  logic       mem_valid, mem_write;
  logic [7:0] mem_addr;
  logic       mem_done = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  llc_dir_ctrl uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_core(req_core), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_state(rsp_state),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_mask(snp_mask),
    .snp_addr(snp_addr), .snp_ack(snp_ack),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_done(mem_done)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [1:0] core;
    logic [7:0] addr;
    logic [3:0] mask;
    logic       kind;
    logic       wb;
    logic [7:0] wba;
    logic       fill;
    logic [2:0] rsp;
    logic [3:0] rq;
  } vec_t;

  // addresses: 10, 20, 30, 40 share set 0; 05 is set 1
  localparam vec_t VECS [24] = '{
    '{2'd0, 2'd0, 8'h10, 4'h0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd2, 4'd2},  // R2 cold read miss
    '{2'd0, 2'd0, 8'h10, 4'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd2, 4'd5},  // R5 sole holder
    '{2'd0, 2'd1, 8'h10, 4'h1, 1'b1, 1'b0, 8'h00, 1'b0, 3'd3, 4'd3},  // R3 forward from E
    '{2'd0, 2'd2, 8'h10, 4'h2, 1'b1, 1'b0, 8'h00, 1'b0, 3'd3, 4'd4},  // R4 forwarder c1
    '{2'd0, 2'd3, 8'h10, 4'h4, 1'b1, 1'b0, 8'h00, 1'b0, 3'd3, 4'd4},  // R4 role moved to c2
    '{2'd0, 2'd1, 8'h10, 4'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd1, 4'd5},  // R5 present non-forwarder
    '{2'd1, 2'd1, 8'h10, 4'hD, 1'b0, 1'b0, 8'h00, 1'b0, 3'd4, 4'd6},  // R6 invalidate others
    '{2'd0, 2'd0, 8'h10, 4'h2, 1'b1, 1'b1, 8'h10, 1'b0, 3'd3, 4'd3},  // R3 M owner, write back
    '{2'd2, 2'd0, 8'h10, 4'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 4'd7},  // R7 forwarder leaves
    '{2'd0, 2'd2, 8'h10, 4'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd3, 4'd7},  // R7 S line local, F
    '{2'd2, 2'd1, 8'h10, 4'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 4'd7},
    '{2'd2, 2'd2, 8'h10, 4'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 4'd7},
    '{2'd0, 2'd3, 8'h10, 4'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd2, 4'd7},  // R7 no holders -> E
    '{2'd1, 2'd3, 8'h10, 4'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd4, 4'd6},  // R6 silent upgrade
    '{2'd0, 2'd2, 8'h20, 4'h0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd2, 4'd8},  // R8 empty way first
    '{2'd0, 2'd0, 8'h30, 4'h8, 1'b0, 1'b1, 8'h10, 1'b1, 3'd2, 4'd8},  // R8 evict M victim
    '{2'd0, 2'd1, 8'h10, 4'h4, 1'b0, 1'b0, 8'h00, 1'b1, 3'd2, 4'd8},  // R8 evict clean victim
    '{2'd0, 2'd1, 8'h05, 4'h0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd2, 4'd2},  // R2 other set
    '{2'd0, 2'd0, 8'h30, 4'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd2, 4'd5},  // R5 hit refreshes LRU
    '{2'd1, 2'd2, 8'h20, 4'h2, 1'b0, 1'b0, 8'h00, 1'b1, 3'd4, 4'd8},  // R8 victim after hit
    '{2'd2, 2'd2, 8'h20, 4'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 4'd7},  // R7 M writeback dirties
    '{2'd0, 2'd3, 8'h10, 4'h1, 1'b0, 1'b0, 8'h00, 1'b1, 3'd2, 4'd8},
    '{2'd0, 2'd0, 8'h30, 4'h0, 1'b0, 1'b1, 8'h20, 1'b1, 3'd2, 4'd8},  // R8 dirty, no holders
    '{2'd2, 2'd1, 8'h40, 4'h0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 4'd7}   // R7 writeback miss
  };

  task automatic chk(input bit ok, input int rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic txn(input logic [1:0] op, input logic [1:0] core, input logic [7:0] addr,
                     output logic [3:0] o_mask, output logic o_kind,
                     output logic o_wb, output logic [7:0] o_wba, output logic o_fill,
                     output logic [2:0] o_rsp, output logic [1:0] o_core,
                     output bit o_got, output bit o_busy_ok, output bit o_pulse_ok);
    int snp_wait = 0;
    int mem_wait = 0;
    o_mask = '0; o_kind = 1'b0; o_wb = 1'b0; o_wba = '0; o_fill = 1'b0;
    o_rsp = '0; o_core = '0; o_got = 1'b0; o_busy_ok = 1'b1; o_pulse_ok = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_core = core; req_addr = addr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 60 && !o_got; cyc++) begin
      snp_ack = 1'b0; mem_done = 1'b0;
      if (snp_valid) begin
        if (req_ready) o_busy_ok = 1'b0;
        o_mask = snp_mask; o_kind = snp_kind;
        snp_wait++;
        if (snp_wait >= 2) begin snp_ack = 1'b1; snp_wait = 0; end
      end
      if (mem_valid) begin
        if (req_ready) o_busy_ok = 1'b0;
        if (mem_write) begin o_wb = 1'b1; o_wba = mem_addr; end
        else o_fill = 1'b1;
        mem_wait++;
        if (mem_wait >= 3) begin mem_done = 1'b1; mem_wait = 0; end
      end
      if (rsp_valid) begin
        o_got = 1'b1; o_rsp = rsp_state; o_core = rsp_core;
      end
      if (!o_got) @(negedge clk);
    end
    @(negedge clk);
    if (rsp_valid) o_pulse_ok = 1'b0;
  endtask

  task automatic run_and_check(input vec_t v);
    logic [3:0] m; logic k, w, f; logic [7:0] wa; logic [2:0] r; logic [1:0] c;
    bit got, busy_ok, pulse_ok;
    int rq;
    rq = int'(v.rq);
    txn(v.op, v.core, v.addr, m, k, w, wa, f, r, c, got, busy_ok, pulse_ok);
    chk(got, 10, "response received", int'(got), 1);
    chk(r == v.rsp, rq, "granted state", int'(r), int'(v.rsp));
    chk(m == v.mask, rq, "snoop mask", int'(m), int'(v.mask));
    if (v.mask != '0) chk(k == v.kind, rq, "snoop kind", int'(k), int'(v.kind));
    chk(w == v.wb, rq, "memory writeback", int'(w), int'(v.wb));
    if (v.wb) chk(wa == v.wba, rq, "writeback address", int'(wa), int'(v.wba));
    chk(f == v.fill, rq, "memory fill", int'(f), int'(v.fill));
    chk(c == v.core, 10, "response core", int'(c), int'(v.core));
    chk(pulse_ok, 10, "single-cycle response", int'(!pulse_ok), 0);
    chk(busy_ok, 9, "ready low while outstanding", int'(!busy_ok), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: idle outputs after reset
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, 1, "ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, 1, "rsp_valid after reset", int'(rsp_valid), 0);
    chk(snp_valid == 1'b0, 1, "snp_valid after reset", int'(snp_valid), 0);
    chk(mem_valid == 1'b0, 1, "mem_valid after reset", int'(mem_valid), 0);

    foreach (VECS[i]) run_and_check(VECS[i]);

    // R1: reset empties the directory; 0x10 was cached, now a clean miss
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, 1, "ready after second reset", int'(req_ready), 1);
    run_and_check('{2'd0, 2'd0, 8'h10, 4'h0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd2, 4'd1});
    run_and_check('{2'd0, 2'd1, 8'h10, 4'h1, 1'b1, 1'b0, 8'h00, 1'b0, 3'd3, 4'd3});
    // R2: read-for-ownership miss grants M with no snoop
    run_and_check('{2'd1, 2'd3, 8'h07, 4'h0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd4, 4'd2});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule